// File: doc/BRIEF.md
# Symbol Timing Recovery Loop

This block closes the symbol-timing loop of a sampled-data receiver. An interpolator outside the block computes signal values between the fixed sample clocks. It does so at the instants this block requests, using the fractional offset this block supplies. The block asks for two interpolants per symbol: one at the expected decision point and one halfway to the next symbol. From each triple (previous decision value, midpoint value, current decision value) it forms a decision-free timing error that does not depend on carrier phase. It smooths that error in a proportional-plus-integral filter and steers a down-counting modulo-1 phase accumulator with it.

Each wrap of the accumulator is an interpolation instant. The residue left at the wrap, scaled by a programmed reciprocal of the nominal step, becomes the fractional offset. Every second instant is a decision point and carries a one-cycle symbol pulse. The two loop gains, the nominal step and its reciprocal sit in four registers behind a small address/data write port. One build can therefore be retuned at run time for a wide range of symbol rates.

Top module: `gardner_timing_loop`

## Requirements
- R1: Synchronous active-low reset clears `strobe`, `bs_pulse`, `mu`, the accumulator, the role toggle and the loop state. It loads step 8192, reciprocal 524288, and both gain shifts 31 (off).
- R2: On every clock the 16-bit accumulator `eta` loses `step` modulo 2^16. When `eta < step` holds at an edge, `strobe` is high for exactly the following cycle.
- R3: With each strobe, `mu` becomes min((eta_before * recip) >> 16, 65535), using the accumulator value before that edge's decrement. Between strobes `mu` holds its value.
- R4: Strobes alternate between decision point and midpoint, and the first strobe after reset is a decision point. `bs_pulse` is high together with `strobe` on decision points only.
- R5: Each `y_vld` pulse delivers one interpolant, with roles alternating and the first being a decision point. At each decision interpolant the error is e = y_mid * (y_prev_decision - y_cur_decision), with all values signed.
- R6: Filter output v = (e >>> kp_shift) + integrator. A shift code of 31 removes that term. A positive e raises the step and so shortens the strobe spacing.
- R7: Each error adds (e >>> ki_shift) to the integrator. With ki_shift 31 the integrator holds its value.
- R8: The step is the nominal word plus v, clamped to 0..65535. A step of 0 produces no strobes.
- R9: Register addresses are 0 for kp_shift (bits 4:0), 1 for ki_shift (bits 4:0), 2 for the nominal step (bits 15:0) and 3 for the reciprocal (bits 19:0, 16 fraction bits). A write takes effect at the next edge and clears both the integrator and v.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_data | input | 20 | Register write value |
| y_vld | input | 1 | Interpolant valid |
| y_in | input | 12 | Signed interpolant |
| strobe | output | 1 | Interpolation instant request |
| mu | output | 16 | Fractional interval, 16 fraction bits |
| bs_pulse | output | 1 | Once-per-symbol decision pulse |

## Verification
The hardest states to reach from the ports are the two ends of the step clamp, where the integrator has grown until the step pins at full scale or at zero. Reaching them takes a sustained error of one sign. The bench emulates the interpolator with a symbol pattern whose midpoint sign is tied to each transition. This gives a constant positive or negative error; with only the integral path enabled, that error drives the loop to strobing on almost every clock and then to a complete stall. Random step and reciprocal writes with the loop idle cover the accumulator, the residue scaling and its saturation.

// File: rtl/gtl_pkg.sv
// Package: shared constants and types for the symbol timing loop.
// Assumes nothing beyond IEEE 1800-2017.
package gtl_pkg;
    localparam int SH_W = 5;

    // Register select codes of the write port
    typedef enum logic [1:0] {
        SEL_KP    = 2'd0,
        SEL_KI    = 2'd1,
        SEL_STEP  = 2'd2,
        SEL_RECIP = 2'd3
    } cfg_sel_e;

    // Shift code that removes a gain path
    localparam logic [SH_W-1:0] SHIFT_OFF = '1;
endpackage

// File: rtl/gtl_cfg_regs.sv
// Module: configuration registers written over the address/data port.
// Assumes CFG_W >= NCO_W and CFG_W >= SH_W; writes land on the next edge.
module gtl_cfg_regs
    import gtl_pkg::*;
#(
    parameter int          NCO_W     = 16,
    parameter int          CFG_W     = 20,
    parameter logic [NCO_W-1:0] DEF_STEP  = 16'd8192,
    parameter logic [CFG_W-1:0] DEF_RECIP = 20'd524288
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [1:0]       sel_i,
    input  logic [CFG_W-1:0] data_i,
    output logic [SH_W-1:0]  kp_sh_o,
    output logic [SH_W-1:0]  ki_sh_o,
    output logic [NCO_W-1:0] step_o,
    output logic [CFG_W-1:0] recip_o
);
    // Register file update with reset defaults
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kp_sh_o <= SHIFT_OFF;
            ki_sh_o <= SHIFT_OFF;
            step_o  <= DEF_STEP;
            recip_o <= DEF_RECIP;
        end else if (wr_i) begin
            case (cfg_sel_e'(sel_i))
                SEL_KP:    kp_sh_o <= data_i[SH_W-1:0];
                SEL_KI:    ki_sh_o <= data_i[SH_W-1:0];
                SEL_STEP:  step_o  <= data_i[NCO_W-1:0];
                SEL_RECIP: recip_o <= data_i;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/gtl_ted.sv
// Module: decision-free timing error detector, two interpolants per symbol.
// Assumes one y_vld per requested instant, first one after reset a decision point.
module gtl_ted #(
    parameter int IN_W  = 12,
    parameter int ERR_W = 2*IN_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    y_vld_i,
    input  logic signed [IN_W-1:0]  y_i,
    output logic signed [ERR_W-1:0] err_o,
    output logic                    err_vld_o
);
    localparam int D_W = IN_W + 1;

    logic signed [IN_W-1:0]  prev_q;
    logic signed [IN_W-1:0]  mid_q;
    logic                    is_mid_q;
    logic signed [D_W-1:0]   diff_w;
    logic signed [ERR_W-1:0] prod_w;

    assign diff_w = D_W'(prev_q) - D_W'(y_i);
    assign prod_w = ERR_W'(mid_q) * ERR_W'(diff_w);

    // Role tracking, sample capture and error formation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= '0;
            mid_q     <= '0;
            is_mid_q  <= 1'b0;
            err_o     <= '0;
            err_vld_o <= 1'b0;
        end else begin
            err_vld_o <= 1'b0;
            if (y_vld_i) begin
                if (!is_mid_q) begin
                    err_o     <= prod_w;
                    err_vld_o <= 1'b1;
                    prev_q    <= y_i;
                end else begin
                    mid_q <= y_i;
                end
                is_mid_q <= ~is_mid_q;
            end
        end
    end

    // R5
    err_from_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_vld_o |-> $past(y_vld_i));
endmodule

// File: rtl/gtl_loop_filter.sv
// Module: proportional-plus-integral loop filter with shift-coded gains.
// Assumes gains are powers of two; shift code all-ones disables a path.
module gtl_loop_filter
    import gtl_pkg::*;
#(
    parameter int ERR_W = 25,
    parameter int ACC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic signed [ERR_W-1:0] err_i,
    input  logic                    err_vld_i,
    input  logic [SH_W-1:0]         kp_sh_i,
    input  logic [SH_W-1:0]         ki_sh_i,
    output logic signed [ACC_W-1:0] v_o
);
    logic signed [ACC_W-1:0] integ_q;
    logic signed [ACC_W-1:0] p_term_w;
    logic signed [ACC_W-1:0] i_term_w;
    logic signed [ACC_W-1:0] integ_nx_w;

    // Scale an error by a power-of-two gain, or drop it
    function automatic logic signed [ACC_W-1:0] scale(
        input logic signed [ERR_W-1:0] e,
        input logic [SH_W-1:0]         sh
    );
        logic signed [ACC_W-1:0] ext;
        ext = ACC_W'(e);
        if (sh == SHIFT_OFF) return '0;
        return ext >>> sh;
    endfunction

    assign p_term_w   = scale(err_i, kp_sh_i);
    assign i_term_w   = scale(err_i, ki_sh_i);
    assign integ_nx_w = integ_q + i_term_w;

    // Integrator and output update once per error
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            integ_q <= '0;
            v_o     <= '0;
        end else if (err_vld_i) begin
            integ_q <= integ_nx_w;
            v_o     <= p_term_w + integ_nx_w;
        end
    end

    // R9
    wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (v_o == '0));

    // R7
    integ_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && ki_sh_i == SHIFT_OFF) |=> $stable(integ_q));
endmodule

// File: rtl/gtl_nco_ctrl.sv
// Module: modulo-1 down-counting accumulator, strobe, fractional interval, symbol pulse.
// Assumes CFG_W > NCO_W; recip has NCO_W fraction bits.
module gtl_nco_ctrl #(
    parameter int NCO_W = 16,
    parameter int CFG_W = 20,
    parameter int ACC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCO_W-1:0]        step_nom_i,
    input  logic [CFG_W-1:0]        recip_i,
    input  logic signed [ACC_W-1:0] v_i,
    output logic                    strobe_o,
    output logic [NCO_W-1:0]        mu_o,
    output logic                    bs_o
);
    localparam int S_W = ACC_W + 2;
    localparam int P_W = NCO_W + CFG_W;
    localparam logic signed [S_W-1:0] STEP_MAX = S_W'((64'd1 << NCO_W) - 64'd1);

    logic [NCO_W-1:0]      eta_q;
    logic                  mid_q;
    logic signed [S_W-1:0] sum_w;
    logic [NCO_W-1:0]      step_w;
    logic                  wrap_w;
    logic [P_W-1:0]        prod_w;
    logic [CFG_W-1:0]      scaled_w;
    logic [NCO_W-1:0]      mu_w;

    // Nominal step plus correction, clamped to the accumulator range
    always_comb begin
        sum_w = S_W'($signed({1'b0, step_nom_i})) + S_W'(v_i);
        if (sum_w < 0)             step_w = '0;
        else if (sum_w > STEP_MAX) step_w = '1;
        else                       step_w = sum_w[NCO_W-1:0];
    end

    assign wrap_w   = (eta_q < step_w);
    assign prod_w   = P_W'(eta_q) * P_W'(recip_i);
    assign scaled_w = prod_w[P_W-1:NCO_W];
    assign mu_w     = (scaled_w[CFG_W-1:NCO_W] != '0) ? '1 : scaled_w[NCO_W-1:0];

    // Accumulator, instant flags and interval capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eta_q    <= '0;
            mid_q    <= 1'b0;
            strobe_o <= 1'b0;
            bs_o     <= 1'b0;
            mu_o     <= '0;
        end else begin
            eta_q    <= eta_q - step_w;
            strobe_o <= wrap_w;
            bs_o     <= wrap_w && !mid_q;
            if (wrap_w) begin
                mu_o  <= mu_w;
                mid_q <= ~mid_q;
            end
        end
    end

    // R8
    zero_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_w == '0) |=> !strobe_o);

    // R3
    mu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_o |-> $stable(mu_o));

    // R4
    bs_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bs_o |-> strobe_o);

    // R4
    bs_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && bs_o) |-> mid_q);
endmodule

// File: rtl/gardner_timing_loop.sv
// Module: top of the symbol timing loop; wires registers, detector, filter, controller.
// Assumes an external interpolator answers each strobe with one y_vld.
module gardner_timing_loop
    import gtl_pkg::*;
#(
    parameter int IN_W     = 12,
    parameter int NCO_W    = 16,
    parameter int CFG_W    = 20,
    parameter int ACC_W    = 32,
    parameter int DEF_STEP = 8192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_addr,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             y_vld,
    input  logic [IN_W-1:0]  y_in,
    output logic             strobe,
    output logic [NCO_W-1:0] mu,
    output logic             bs_pulse
);
    localparam int ERR_W = 2*IN_W + 1;
    localparam logic [NCO_W-1:0] STEP0  = NCO_W'(DEF_STEP);
    localparam logic [CFG_W-1:0] RECIP0 = CFG_W'((64'd1 << (2*NCO_W)) / 64'(DEF_STEP));

    logic [SH_W-1:0]         kp_sh;
    logic [SH_W-1:0]         ki_sh;
    logic [NCO_W-1:0]        step_nom;
    logic [CFG_W-1:0]        recip;
    logic signed [ERR_W-1:0] err;
    logic                    err_vld;
    logic signed [ACC_W-1:0] v;

    gtl_cfg_regs #(.NCO_W(NCO_W), .CFG_W(CFG_W), .DEF_STEP(STEP0), .DEF_RECIP(RECIP0)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr), .sel_i(cfg_addr), .data_i(cfg_data),
        .kp_sh_o(kp_sh), .ki_sh_o(ki_sh), .step_o(step_nom), .recip_o(recip)
    );

    gtl_ted #(.IN_W(IN_W), .ERR_W(ERR_W)) u_ted (
        .clk(clk), .rst_n(rst_n), .y_vld_i(y_vld), .y_i($signed(y_in)),
        .err_o(err), .err_vld_o(err_vld)
    );

    gtl_loop_filter #(.ERR_W(ERR_W), .ACC_W(ACC_W)) u_filt (
        .clk(clk), .rst_n(rst_n), .clr_i(cfg_wr), .err_i(err), .err_vld_i(err_vld),
        .kp_sh_i(kp_sh), .ki_sh_i(ki_sh), .v_o(v)
    );

    gtl_nco_ctrl #(.NCO_W(NCO_W), .CFG_W(CFG_W), .ACC_W(ACC_W)) u_nco (
        .clk(clk), .rst_n(rst_n), .step_nom_i(step_nom), .recip_i(recip), .v_i(v),
        .strobe_o(strobe), .mu_o(mu), .bs_o(bs_pulse)
    );
endmodule

// File: tb/sim_gardner_timing_loop.sv
`timescale 1ns/1ps
module sim_gardner_timing_loop;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [19:0] cfg_data = '0;
    logic        y_vld = 1'b0;
    logic [11:0] y_in = '0;
    logic        strobe;
    logic [15:0] mu;
    logic        bs_pulse;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 0;
    bit  model_on = 0;
    int  pat_mode = 0;

    // model state for the idle loop (v = 0)
    longint m_eta = 0, m_step = 8192, m_recip = 524288, m_mu = 0;
    bit m_strobe = 0, m_bs = 0, m_mid = 0;

    always #2.5 clk = ~clk;

    gardner_timing_loop u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .y_vld(y_vld), .y_in(y_in), .strobe(strobe), .mu(mu), .bs_pulse(bs_pulse)
    );

    function automatic longint mu_ref(longint eta, longint rc);
        longint s;
        s = (eta * rc) >> 16;
        return (s > 65535) ? 65535 : s;
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cfg_write(logic [1:0] a, logic [19:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_data = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic window(int cyc, output int ns, output int nb);
        ns = 0; nb = 0;
        repeat (cyc) begin
            @(negedge clk);
            ns += int'(strobe);
            nb += int'(bs_pulse);
        end
    endtask

    // reference model of accumulator, interval and symbol pulse (R2, R3, R4, R9)
    always @(posedge clk) begin
        if (!rst_n) begin
            m_eta = 0; m_mid = 0; m_mu = 0; m_strobe = 0; m_bs = 0;
            m_step = 8192; m_recip = 524288;
        end else begin
            m_strobe = (m_eta < m_step);
            m_bs = m_strobe && !m_mid;
            if (m_strobe) begin
                m_mu = mu_ref(m_eta, m_recip);
                m_mid = !m_mid;
            end
            m_eta = (m_eta - m_step) & 64'hFFFF;
            if (cfg_wr && cfg_addr == 2'd2) m_step = cfg_data[15:0];
            if (cfg_wr && cfg_addr == 2'd3) m_recip = cfg_data;
        end
    end

    // per-cycle comparison while the loop is idle
    always @(negedge clk) begin
        if (model_on && !done) begin
            check(strobe == m_strobe, "R2 strobe", strobe, m_strobe);
            check(mu == 16'(m_mu), "R3 mu", mu, m_mu);
            check(bs_pulse == m_bs, "R4 bs_pulse", bs_pulse, m_bs);
        end
    end

    // interpolator emulation: answers each strobe one cycle later (R5)
    initial begin
        int sym = 0;
        bit role_mid = 0;
        int a_amp = 100, m_amp = 64, sv;
        forever begin
            @(negedge clk);
            y_vld = strobe;
            if (strobe) begin
                sv = (sym % 2 == 0) ? a_amp : -a_amp;
                if (pat_mode == 0)      y_in = '0;
                else if (!role_mid)     y_in = 12'(sv);
                else if (pat_mode == 1) y_in = 12'((sv > 0) ? m_amp : -m_amp);
                else                    y_in = 12'((sv > 0) ? -m_amp : m_amp);
                if (role_mid) sym++;
                role_mid = !role_mid;
            end
        end
    end

    initial begin
        int ns, nb, w;
        logic [19:0] rc;
        void'($urandom(32'd4021));
        repeat (4) @(negedge clk);
        // R1 reset values
        check(strobe == 1'b0, "R1 strobe", strobe, 0);
        check(bs_pulse == 1'b0, "R1 bs_pulse", bs_pulse, 0);
        check(mu == '0, "R1 mu", mu, 0);
        rst_n = 1'b1;
        model_on = 1;
        repeat (300) @(negedge clk);
        // random nominal step and reciprocal writes with the loop idle (R2, R3, R9)
        for (int i = 0; i < 24; i++) begin
            w = 2000 + int'($urandom % 28000);
            if (i % 3 == 0) rc = 20'($urandom);
            else rc = ((64'd1 << 32) / w > 64'hFFFFF) ? 20'hFFFFF : 20'((64'd1 << 32) / w);
            cfg_write(2'd2, 20'(w));
            cfg_write(2'd3, rc);
            repeat (100 + int'($urandom % 300)) @(negedge clk);
        end
        // directed corners: zero step (R8) and full step
        cfg_write(2'd2, 20'd0);
        repeat (200) @(negedge clk);
        cfg_write(2'd2, 20'd65535);
        repeat (200) @(negedge clk);
        cfg_write(2'd2, 20'd8192);
        cfg_write(2'd3, 20'd524288);
        repeat (100) @(negedge clk);
        model_on = 0;

        // R6 positive error, proportional only: step 8992
        pat_mode = 1;
        cfg_write(2'd1, 20'd31);
        cfg_write(2'd0, 20'd4);
        repeat (300) @(negedge clk);
        window(2000, ns, nb);
        check(ns >= 274 && ns <= 275, "R6 R5 positive error spacing", ns, 274);
        check(nb * 2 >= ns - 1 && nb * 2 <= ns + 1, "R4 symbol pulses per strobe", nb, ns / 2);

        // R6 negative error: step 7392
        pat_mode = 2;
        cfg_write(2'd0, 20'd4);
        repeat (300) @(negedge clk);
        window(2000, ns, nb);
        check(ns >= 225 && ns <= 226, "R6 R5 negative error spacing", ns, 225);

        // R7 integral path only, positive error drives the step to the top clamp (R8)
        pat_mode = 1;
        cfg_write(2'd0, 20'd31);
        cfg_write(2'd1, 20'd4);
        repeat (1500) @(negedge clk);
        window(100, ns, nb);
        check(ns >= 99, "R7 R8 top clamp strobe rate", ns, 99);
        check(nb >= 49 && nb <= 51, "R4 pulses at top clamp", nb, 50);

        // R7 negative error winds integrator down to the zero clamp (R8)
        pat_mode = 2;
        repeat (10000) @(negedge clk);
        window(500, ns, nb);
        check(ns == 0, "R8 stall at zero step", ns, 0);
        check(nb == 0, "R8 no symbol pulse when stalled", nb, 0);

        // R9 write clears the loop and restores nominal spacing
        pat_mode = 0;
        cfg_write(2'd0, 20'd31);
        cfg_write(2'd2, 20'd8192);
        repeat (100) @(negedge clk);
        cfg_write(2'd1, 20'd31);
        repeat (20) @(negedge clk);
        window(800, ns, nb);
        check(ns == 100, "R9 nominal spacing after clear", ns, 100);
        check(nb == 50, "R4 pulses after clear", nb, 50);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // watchdog
    initial begin
        #(190000 * 5);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule